// File: doc/BRIEF.md
# Dual-Clock FIFO with Block Replay

This block moves data words from a write clock domain to an unrelated read clock domain through an inferred dual-port memory. Each side keeps its own address register and a delayed copy of the other side's address. The copy arrives through a request/acknowledge handshake that carries a whole snapshot at a time. From these two values, each side derives its own occupancy count and its own set of status flags. Because the copies lag, the flags and counts of one side follow events on the other side only after a few cycles. A count seen from the far side can also advance in steps larger than one.

On top of ordinary first-in-first-out use, the read side offers two controls. The first is a replay mode: the read address falls back to zero right after the last written word is delivered, so a block written once is streamed again and again to a fast consumer. The second is a rewind input, which returns the read address to zero at any moment. The five status flags are active low (0 means the condition holds). Overflow and underflow are separate sticky bits, active high. A single asynchronous reset clears both domains.

Top module: `dcfifo_replay`

## Requirements
- R1: While and after reset, both sides show an empty, not-full state: the empty and almost-empty flags are 0; the half-full, almost-full and full flags are 1; both counts read 0; overflow and underflow are 0.
- R2: Words come out in the order they were written. The read data is registered and is valid one read-clock cycle after the cycle that accepts the read.
- R3: Outside replay mode, rd_empty_n is 0 exactly when the read address equals the read domain's copy of the write address. A read is accepted only when rd_empty_n is 1.
- R4: Out of DEPTH slots, one is always left unused. wr_full_n drops to 0 when DEPTH-1 words are held. A write attempted while wr_full_n is 0 is discarded, sets wr_overflow, and leaves every stored word intact. wr_overflow stays set until reset.
- R5: Each count equals that domain's write address view minus its read address view, modulo DEPTH. It is presented zero-extended on a 16-bit output. Once both sides are quiet, both counts equal the true occupancy.
- R6: An address reaches the other domain only as a complete snapshot after a handshake. A write is not visible on the read side within the first read-clock cycle after it is accepted, and it becomes visible once the traffic settles.
- R7: On either side, the almost-empty flag is 0 when that side's count is below AE_LVL. The half-full flag is 0 when that side's count is at least DEPTH/2.
- R8: The almost-full flag is 0 when the free room (DEPTH-1 minus count) is below AF_LVL. While it is 1, at least AF_LVL more words can be written.
- R9: A read attempted while rd_empty_n is 0 leaves the read address unchanged and sets rd_underflow. rd_underflow stays set until reset.
- R10: When rd_cyclic is 1, reading the last written word returns the read address to 0, so the block repeats. Also, rd_empty_n stays 1 as long as the write address view is non-zero.
- R11: A cycle with rd_rewind at 1 sets the read address to 0 in that cycle. It wins over a read in the same cycle, and that read is not accepted.
- R12: A reset that is asserted while wr_en is 1 leaves the FIFO fully empty, with no stale word readable afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset for both domains, active high |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_empty_n | output | 1 | Write-side empty flag, 0 = empty |
| wr_aempty_n | output | 1 | Write-side almost-empty flag, 0 = count below AE_LVL |
| wr_half_n | output | 1 | Write-side half-full flag, 0 = count at least DEPTH/2 |
| wr_afull_n | output | 1 | Write-side almost-full flag, 0 = room below AF_LVL |
| wr_full_n | output | 1 | Write-side full flag, 0 = full |
| wr_overflow | output | 1 | Sticky: a write hit a full FIFO |
| wr_count | output | 16 | Occupancy as seen in the write domain |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_rewind | input | 1 | Return the read address to 0 |
| rd_cyclic | input | 1 | Replay mode enable |
| rd_data | output | DATA_W | Registered read word |
| rd_empty_n | output | 1 | Read-side empty flag, 0 = empty |
| rd_aempty_n | output | 1 | Read-side almost-empty flag |
| rd_half_n | output | 1 | Read-side half-full flag |
| rd_afull_n | output | 1 | Read-side almost-full flag |
| rd_full_n | output | 1 | Read-side full flag |
| rd_underflow | output | 1 | Sticky: a read hit an empty FIFO |
| rd_count | output | 16 | Occupancy as seen in the read domain |

## Verification
The assertions assume three things about the inputs. First, the write block in replay mode is written from address zero and never wraps. Second, rd_rewind and rd_en are not driven in the same cycle, except when the test exercises the rewind priority on purpose. Third, reset is held across several edges of both clocks. The stimulus keeps to these assumptions: it resets before each replay or rewind scenario, pulses rewind alone, and holds reset for three write-clock edges. Read data is checked only for reads the bench expects the block to accept. Any check that depends on the other domain's view is made only after the bench has idled long enough for the snapshot handshake to complete.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    // Active-low status group produced by each side
    typedef struct packed {
        logic empty_n;
        logic aempty_n;
        logic half_n;
        logic afull_n;
        logic full_n;
    } fdc_flags_t;

endpackage

// File: rtl/fdc_snapshot.sv
// Carries a multi-bit value from a source clock to a destination clock as
// a whole snapshot, using a toggle request and a toggle acknowledge.
module fdc_snapshot #(
    parameter int W = 12
) (
    input  logic         rst,
    input  logic         s_clk,
    input  logic [W-1:0] s_val,
    input  logic         d_clk,
    output logic [W-1:0] d_val
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic         req;
        logic         ack_m;
        logic         ack_s;
    } src_t;

    typedef struct packed {
        logic         req_m;
        logic         req_s;
        logic         seen;
        logic [W-1:0] out;
    } dst_t;

    src_t src_d, src_q;
    dst_t dst_d, dst_q;

    always_comb begin
        src_d       = src_q;
        src_d.ack_m = dst_q.seen;
        src_d.ack_s = src_q.ack_m;
        if (src_q.req == src_q.ack_s) begin
            src_d.hold = s_val;
            src_d.req  = ~src_q.req;
        end
    end

    always_ff @(posedge s_clk or posedge rst) begin
        if (rst) src_q <= '0;
        else     src_q <= src_d;
    end

    always_comb begin
        dst_d       = dst_q;
        dst_d.req_m = src_q.req;
        dst_d.req_s = dst_q.req_m;
        if (dst_q.req_s != dst_q.seen) begin
            dst_d.out  = src_q.hold;
            dst_d.seen = dst_q.req_s;
        end
    end

    always_ff @(posedge d_clk or posedge rst) begin
        if (rst) dst_q <= '0;
        else     dst_q <= dst_d;
    end

    assign d_val = dst_q.out;

    // R6
    hold_stable_chk: assert property (@(posedge s_clk) disable iff (rst)
        (src_q.req != src_q.ack_s) |=> $stable(src_q.hold));

endmodule

// File: rtl/fdc_status.sv
// Count and active-low flags from one domain's pair of address views.
module fdc_status import fdc_pkg::*; #(
    parameter int AW     = 12,
    parameter int DEPTH  = 4096,
    parameter int AF_LVL = 16,
    parameter int AE_LVL = 544
) (
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] rd_ptr,
    input  logic          replay,
    output logic [15:0]   count,
    output fdc_flags_t    flags
);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CAP_V  = CW'(DEPTH - 1);
    localparam logic [CW-1:0] HALF_V = CW'(DEPTH / 2);
    localparam logic [CW-1:0] AE_V   = CW'(AE_LVL);
    localparam logic [CW-1:0] AF_V   = CW'(AF_LVL);

    logic [AW-1:0] diff;
    logic [CW-1:0] used;
    logic [CW-1:0] room;

    always_comb begin
        diff           = wr_ptr - rd_ptr;
        used           = {1'b0, diff};
        room           = CAP_V - used;
        flags.empty_n  = !((wr_ptr == rd_ptr) && !(replay && (wr_ptr != '0)));
        flags.aempty_n = !(used < AE_V);
        flags.half_n   = !(used >= HALF_V);
        flags.afull_n  = !(room < AF_V);
        flags.full_n   = !(AW'(wr_ptr + 1'b1) == rd_ptr);
        count          = 16'(diff);
    end

endmodule

// File: rtl/fdc_wr_ctl.sv
module fdc_wr_ctl #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          full_n,
    output logic [AW-1:0] waddr,
    output logic          mem_we,
    output logic          ovf
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          ovf;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (wr_en) begin
            if (full_n) begin
                mem_we    = 1'b1;
                st_d.addr = st_q.addr + 1'b1;
            end else begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign waddr = st_q.addr;
    assign ovf   = st_q.ovf;

    // R4
    drop_on_full_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full_n) |=> $stable(waddr));
    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !full_n) |=> ovf);
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

endmodule

// File: rtl/fdc_rd_ctl.sv
module fdc_rd_ctl #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          rewind,
    input  logic          cyclic,
    input  logic          empty_n,
    input  logic [AW-1:0] wview,
    output logic [AW-1:0] raddr,
    output logic          mem_re,
    output logic          unf
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          unf;
    } rst_t;

    rst_t st_d, st_q;
    logic [AW-1:0] step;

    always_comb begin
        st_d   = st_q;
        mem_re = 1'b0;
        step   = st_q.addr + 1'b1;
        if (rewind) begin
            st_d.addr = '0;
        end else if (rd_en) begin
            if (empty_n) begin
                mem_re    = 1'b1;
                st_d.addr = (cyclic && (step == wview)) ? '0 : step;
            end else begin
                st_d.unf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign raddr = st_q.addr;
    assign unf   = st_q.unf;

    // R11
    rewind_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (raddr == '0));
    // R9
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty_n && !rewind) |=> $stable(raddr));
    // R9
    unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf);

endmodule

// File: rtl/fdc_mem.sv
module fdc_mem #(
    parameter int W     = 64,
    parameter int DEPTH = 4096,
    parameter int AW    = 12
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];
    logic [W-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata_q <= store[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dcfifo_replay.sv
module dcfifo_replay import fdc_pkg::*; #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4096,
    parameter int AF_LVL = 16,
    parameter int AE_LVL = 544
) (
    input  logic              rst,
    input  logic              wclk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_empty_n,
    output logic              wr_aempty_n,
    output logic              wr_half_n,
    output logic              wr_afull_n,
    output logic              wr_full_n,
    output logic              wr_overflow,
    output logic [15:0]       wr_count,
    input  logic              rclk,
    input  logic              rd_en,
    input  logic              rd_rewind,
    input  logic              rd_cyclic,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty_n,
    output logic              rd_aempty_n,
    output logic              rd_half_n,
    output logic              rd_afull_n,
    output logic              rd_full_n,
    output logic              rd_underflow,
    output logic [15:0]       rd_count
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] waddr, raddr, wview_r, rview_w;
    logic          mem_we, mem_re;
    fdc_flags_t    wflags, rflags;

    fdc_wr_ctl #(.AW(AW)) u_wr (
        .clk(wclk), .rst(rst), .wr_en(wr_en), .full_n(wflags.full_n),
        .waddr(waddr), .mem_we(mem_we), .ovf(wr_overflow)
    );

    fdc_rd_ctl #(.AW(AW)) u_rd (
        .clk(rclk), .rst(rst), .rd_en(rd_en), .rewind(rd_rewind),
        .cyclic(rd_cyclic), .empty_n(rflags.empty_n), .wview(wview_r),
        .raddr(raddr), .mem_re(mem_re), .unf(rd_underflow)
    );

    fdc_snapshot #(.W(AW)) u_w2r (
        .rst(rst), .s_clk(wclk), .s_val(waddr), .d_clk(rclk), .d_val(wview_r)
    );

    fdc_snapshot #(.W(AW)) u_r2w (
        .rst(rst), .s_clk(rclk), .s_val(raddr), .d_clk(wclk), .d_val(rview_w)
    );

    fdc_status #(.AW(AW), .DEPTH(DEPTH), .AF_LVL(AF_LVL), .AE_LVL(AE_LVL)) u_wstat (
        .wr_ptr(waddr), .rd_ptr(rview_w), .replay(1'b0),
        .count(wr_count), .flags(wflags)
    );

    fdc_status #(.AW(AW), .DEPTH(DEPTH), .AF_LVL(AF_LVL), .AE_LVL(AE_LVL)) u_rstat (
        .wr_ptr(wview_r), .rd_ptr(raddr), .replay(rd_cyclic),
        .count(rd_count), .flags(rflags)
    );

    fdc_mem #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .re(mem_re), .raddr(raddr), .rdata(rd_data)
    );

    assign wr_empty_n  = wflags.empty_n;
    assign wr_aempty_n = wflags.aempty_n;
    assign wr_half_n   = wflags.half_n;
    assign wr_afull_n  = wflags.afull_n;
    assign wr_full_n   = wflags.full_n;
    assign rd_empty_n  = rflags.empty_n;
    assign rd_aempty_n = rflags.aempty_n;
    assign rd_half_n   = rflags.half_n;
    assign rd_afull_n  = rflags.afull_n;
    assign rd_full_n   = rflags.full_n;

endmodule

// File: tb/dcfifo_replay_bench.sv
module dcfifo_replay_bench;
    localparam int W = 16;
    localparam int D = 16;

    logic          rst = 1'b1;
    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_rewind = 1'b0;
    logic          rd_cyclic = 1'b0;
    logic          wr_empty_n, wr_aempty_n, wr_half_n, wr_afull_n, wr_full_n, wr_overflow;
    logic          rd_empty_n, rd_aempty_n, rd_half_n, rd_afull_n, rd_full_n, rd_underflow;
    logic [15:0]   wr_count, rd_count;
    logic [W-1:0]  rd_data;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [W-1:0] expq[$];
    bit pend = 0;

    always #4 wclk = ~wclk;
    always #5.5 rclk = ~rclk;

    dcfifo_replay #(.DATA_W(W), .DEPTH(D), .AF_LVL(3), .AE_LVL(4)) u_dcfifo_replay (
        .rst(rst), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_empty_n(wr_empty_n), .wr_aempty_n(wr_aempty_n), .wr_half_n(wr_half_n),
        .wr_afull_n(wr_afull_n), .wr_full_n(wr_full_n), .wr_overflow(wr_overflow),
        .wr_count(wr_count), .rclk(rclk), .rd_en(rd_en), .rd_rewind(rd_rewind),
        .rd_cyclic(rd_cyclic), .rd_data(rd_data), .rd_empty_n(rd_empty_n),
        .rd_aempty_n(rd_aempty_n), .rd_half_n(rd_half_n), .rd_afull_n(rd_afull_n),
        .rd_full_n(rd_full_n), .rd_underflow(rd_underflow), .rd_count(rd_count)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor: compares each accepted read against the scoreboard queue
    always @(negedge rclk) begin
        if (pend) begin
            if (expq.size() == 0) chk("R2 unexpected read", 1, 0);
            else chk("R2 read data", int'(rd_data), int'(expq.pop_front()));
        end
        pend = rd_en && rd_empty_n && !rd_rewind && !rst;
    end

    task automatic put(logic [W-1:0] v, bit expect_ok);
        @(posedge wclk); #1;
        wr_en = 1'b1; wr_data = v;
        if (expect_ok) expq.push_back(v);
        @(posedge wclk); #1;
        wr_en = 1'b0;
    endtask

    task automatic take(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rclk); #1;
            rd_en = 1'b1;
        end
        @(posedge rclk); #1;
        rd_en = 1'b0;
        @(negedge rclk); @(negedge rclk);
    endtask

    task automatic settle();
        repeat (30) @(posedge rclk);
        @(negedge rclk);
    endtask

    task automatic do_reset(bit with_write);
        @(posedge wclk); #1;
        if (with_write) begin wr_en = 1'b1; wr_data = 16'h0BAD; end
        rst = 1'b1;
        repeat (3) @(posedge wclk);
        repeat (3) @(posedge rclk);
        #1;
        wr_en = 1'b0;
        expq.delete();
        rst = 1'b0;
        settle();
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge wclk);
        @(negedge rclk);
        // R1 reset state
        chk("R1 rd_empty_n", rd_empty_n, 0);
        chk("R1 rd_aempty_n", rd_aempty_n, 0);
        chk("R1 wr_empty_n", wr_empty_n, 0);
        chk("R1 wr_full_n", wr_full_n, 1);
        chk("R1 wr_afull_n", wr_afull_n, 1);
        chk("R1 wr_half_n", wr_half_n, 1);
        chk("R1 rd_count", rd_count, 0);
        chk("R1 wr_count", wr_count, 0);
        chk("R1 sticky bits", {wr_overflow, rd_underflow}, 0);
        #1 rst = 1'b0;
        settle();

        // R6: a single write is not visible on the read side in the first read cycle
        put(16'h1001, 1);
        @(negedge rclk);
        chk("R6 read side still empty", rd_empty_n, 0);
        put(16'h1002, 1);
        put(16'h1003, 1);
        settle();
        chk("R5 rd_count after 3", rd_count, 3);
        chk("R5 wr_count after 3", wr_count, 3);
        chk("R7 rd_aempty_n at 3", rd_aempty_n, 0);
        chk("R3 rd_empty_n with data", rd_empty_n, 1);
        put(16'h1004, 1);
        settle();
        chk("R7 rd_aempty_n at 4", rd_aempty_n, 1);
        chk("R6 wr side agrees", wr_count, 4);
        take(4);
        chk("R2 all words delivered", expq.size(), 0);
        settle();
        chk("R3 rd_empty_n drained", rd_empty_n, 0);
        chk("R5 wr_count drained", wr_count, 0);

        // R7/R8/R4 fill sequence
        for (int i = 0; i < 7; i++) put(16'h2000 + 16'(i), 1);
        @(negedge wclk);
        chk("R7 wr_half_n at 7", wr_half_n, 1);
        put(16'h2007, 1);
        @(negedge wclk);
        chk("R7 wr_half_n at 8", wr_half_n, 0);
        settle();
        chk("R7 rd_half_n at 8", rd_half_n, 0);
        chk("R5 rd_count at 8", rd_count, 8);
        for (int i = 8; i < 12; i++) put(16'h2000 + 16'(i), 1);
        @(negedge wclk);
        chk("R8 wr_afull_n at 12", wr_afull_n, 1);
        put(16'h200C, 1);
        @(negedge wclk);
        chk("R8 wr_afull_n at 13", wr_afull_n, 0);
        put(16'h200D, 1);
        @(negedge wclk);
        chk("R4 wr_full_n at 14", wr_full_n, 1);
        put(16'h200E, 1);
        @(negedge wclk);
        chk("R4 wr_full_n at 15", wr_full_n, 0);
        chk("R4 no overflow yet", wr_overflow, 0);
        put(16'hDEAD, 0);
        @(negedge wclk);
        chk("R4 wr_overflow", wr_overflow, 1);
        chk("R4 wr_count stays 15", wr_count, 15);
        settle();
        take(15);
        chk("R4 stored words intact", expq.size(), 0);
        settle();
        chk("R4 overflow sticky", wr_overflow, 1);

        // R9 underflow
        take(1);
        chk("R9 rd_underflow", rd_underflow, 1);
        chk("R9 rd_count stays 0", rd_count, 0);
        put(16'h7777, 1);
        settle();
        take(1);
        chk("R9 address not moved", expq.size(), 0);

        // R12 reset coincident with a write
        do_reset(1);
        chk("R12 rd_empty_n", rd_empty_n, 0);
        chk("R12 wr_count", wr_count, 0);
        chk("R12 rd_count", rd_count, 0);
        chk("R1 sticky cleared", {wr_overflow, rd_underflow}, 0);
        put(16'h5A5A, 1);
        settle();
        chk("R12 one word only", rd_count, 1);
        take(1);
        chk("R12 no stale word", expq.size(), 0);

        // R10 cyclic replay
        do_reset(0);
        put(16'hA001, 0); put(16'hA002, 0); put(16'hA003, 0);
        settle();
        rd_cyclic = 1'b1;
        for (int k = 0; k < 7; k++) expq.push_back(16'hA001 + 16'(k % 3));
        take(7);
        chk("R10 replay sequence", expq.size(), 0);
        chk("R10 empty suppressed", rd_empty_n, 1);
        rd_cyclic = 1'b0;

        // R11 rewind
        do_reset(0);
        put(16'hC000, 1); put(16'hC001, 1); put(16'hC002, 0); put(16'hC003, 0);
        settle();
        take(2);
        chk("R2 first two", expq.size(), 0);
        @(posedge rclk); #1 rd_rewind = 1'b1;
        @(posedge rclk); #1 rd_rewind = 1'b0;
        settle();
        chk("R11 rd_count after rewind", rd_count, 4);
        chk("R11 wr_count after rewind", wr_count, 4);
        for (int k = 0; k < 4; k++) expq.push_back(16'hC000 + 16'(k));
        take(4);
        chk("R11 replayed from zero", expq.size(), 0);

        finish_run();
    end

endmodule